// File: doc/BRIEF.md
# Coalescing Unordered Store Buffer

This block parks store misses by cache-line address until write permission for the line arrives. It is a small, fully associative array of entries. A store whose line is already parked folds its bytes into that line's entry, so a missing line never occupies more than one slot. Stores that already own the line in the L1 pass by the buffer untouched. Each entry also keeps one speculative-read flag and one speculative-write flag. These flags are OR-accumulated across merged stores.

When a permission grant names a line the buffer holds, that entry is handed off to the L1 one cycle later. The line, the merged bytes, the byte mask and both speculation flags leave together, and the slot is freed. Entries keep no age order, so any slot may leave first. The pipeline sees an empty flag and a full flag. When a store needs a fresh slot and none is free, the block refuses it with a stall in the same cycle.

Top module: `coal_store_buf`

## Requirements
- R1: After reset the buffer is empty (`sb_empty`=1, `sb_full`=0) and `drain_valid` is 0.
- R2: A store presented with `st_l1_hit`=1 changes no entry. A later grant for that line produces no drain unless a buffered store also targets that line.
- R3: A store (with `st_l1_hit`=0 and a nonzero `st_be`) to a line that is not held takes a free slot. Its mask is `st_be`, where bit b covers data bits [8b+7:8b]. Bytes it does not write read as zero. Its flags are `st_spec_rd`/`st_spec_wr`.
- R4: A store to a held line merges into that line's only entry. Enabled bytes replace older bytes, the mask becomes the OR of both masks, and each flag becomes the OR of both flags. No second entry is created.
- R5: `sb_full` is 1 exactly when all ENTRIES slots are valid. A store that needs a new slot while full raises `st_stall` in that cycle and is discarded. A store to a held line is accepted while full.
- R6: A grant for a held line makes `drain_valid`=1 on the next cycle, with that entry's line, data, mask and both flags, and frees the slot. Grants may free entries in any order.
- R7: A grant for a line that is not held changes nothing and produces no drain.
- R8: `sb_empty` rises in the same cycle that `drain_valid` reports the last held entry.
- R9: When a store and a grant name the same held line in one cycle, the drained data, mask and flags already include that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store presented this cycle |
| st_l1_hit | input | 1 | Store owns the line in L1; bypass the buffer |
| st_line | input | LINE_W | Store line address |
| st_data | input | LINE_BYTES*8 | Store data, laid out over the line |
| st_be | input | LINE_BYTES | Store byte enables |
| st_spec_rd | input | 1 | Speculative-read flag to attach |
| st_spec_wr | input | 1 | Speculative-write flag to attach |
| st_stall | output | 1 | Store refused: no free slot |
| grant_valid | input | 1 | Write permission arrived this cycle |
| grant_line | input | LINE_W | Line address of the grant |
| drain_valid | output | 1 | Entry being handed to L1 |
| drain_line | output | LINE_W | Line address of the drained entry |
| drain_data | output | LINE_BYTES*8 | Merged data of the drained entry |
| drain_be | output | LINE_BYTES | Byte mask of the drained entry |
| drain_spec_rd | output | 1 | Speculative-read flag of the drained entry |
| drain_spec_wr | output | 1 | Speculative-write flag of the drained entry |
| sb_empty | output | 1 | No slot valid |
| sb_full | output | 1 | All slots valid |

## Verification
The two functions that can coincide are a store merging into a held line and the grant that releases the same line. When both arrive in one cycle, the drained entry must already carry the new bytes and flags, and the slot must not stay valid. A directed case aims a store and a grant at one held line in a single cycle. The random phase draws stores and grants from a shared pool of twelve lines, so these collisions, and allocations racing a release elsewhere, recur often. Each drained entry is judged against a bench model that applies the store before the release.

// File: rtl/csb_pkg.sv
`timescale 1ns/1ps
package csb_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } csb_spec_t;
endpackage

// File: rtl/csb_tag_match.sv
`timescale 1ns/1ps
module csb_tag_match #(
  parameter int N = 8,
  parameter int W = 26
) (
  input  logic [N-1:0] valid,
  input  logic [W-1:0] tags [N],
  input  logic [W-1:0] key,
  output logic [N-1:0] hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = valid[i] && (tags[i] == key);
  end
endmodule

// File: rtl/csb_free_pick.sv
`timescale 1ns/1ps
module csb_free_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] valid,
  output logic [N-1:0] free_oh,
  output logic         any_free
);
  always_comb begin
    free_oh  = '0;
    any_free = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!valid[i] && !any_free) begin
        free_oh[i] = 1'b1;
        any_free   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_store_buf.sv
`timescale 1ns/1ps
module coal_store_buf
  import csb_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int LINE_W     = 26,
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    st_valid,
  input  logic                    st_l1_hit,
  input  logic [LINE_W-1:0]       st_line,
  input  logic [LINE_BYTES*8-1:0] st_data,
  input  logic [LINE_BYTES-1:0]   st_be,
  input  logic                    st_spec_rd,
  input  logic                    st_spec_wr,
  output logic                    st_stall,
  input  logic                    grant_valid,
  input  logic [LINE_W-1:0]       grant_line,
  output logic                    drain_valid,
  output logic [LINE_W-1:0]       drain_line,
  output logic [LINE_BYTES*8-1:0] drain_data,
  output logic [LINE_BYTES-1:0]   drain_be,
  output logic                    drain_spec_rd,
  output logic                    drain_spec_wr,
  output logic                    sb_empty,
  output logic                    sb_full
);
  localparam int DATA_W = LINE_BYTES * 8;

  logic [ENTRIES-1:0]    valid_q;
  logic [LINE_W-1:0]     tag_q  [ENTRIES];
  logic [DATA_W-1:0]     data_q [ENTRIES];
  logic [LINE_BYTES-1:0] be_q   [ENTRIES];
  csb_spec_t             spec_q [ENTRIES];

  logic [ENTRIES-1:0] st_match, gr_match, free_oh, alloc_en, wr_en, drain_hit;
  logic               any_free, full_now, st_take, st_new;

  logic [DATA_W-1:0]     view_data [ENTRIES];
  logic [LINE_BYTES-1:0] view_be   [ENTRIES];
  csb_spec_t             view_spec [ENTRIES];

  logic [DATA_W-1:0]     sel_data;
  logic [LINE_BYTES-1:0] sel_be;
  csb_spec_t             sel_spec;

  csb_tag_match #(.N(ENTRIES), .W(LINE_W)) u_st_cam (
    .valid(valid_q), .tags(tag_q), .key(st_line), .hit(st_match)
  );

  csb_tag_match #(.N(ENTRIES), .W(LINE_W)) u_gr_cam (
    .valid(valid_q), .tags(tag_q), .key(grant_line), .hit(gr_match)
  );

  csb_free_pick #(.N(ENTRIES)) u_free (
    .valid(valid_q), .free_oh(free_oh), .any_free(any_free)
  );

  assign full_now  = ~any_free;
  assign st_take   = st_valid && !st_l1_hit;
  assign st_new    = st_take && !(|st_match) && !full_now;
  assign st_stall  = st_take && !(|st_match) && full_now;
  assign alloc_en  = st_new ? free_oh : '0;
  assign wr_en     = (st_take ? st_match : '0) | alloc_en;
  assign drain_hit = grant_valid ? gr_match : '0;
  assign sb_full   = full_now;
  assign sb_empty  = ~(|valid_q);

  // Per-entry view after this cycle's store (fresh slot starts cleared)
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      view_be[i]      = alloc_en[i] ? '0 : be_q[i];
      view_data[i]    = alloc_en[i] ? '0 : data_q[i];
      view_spec[i]    = alloc_en[i] ? '0 : spec_q[i];
      if (wr_en[i]) begin
        view_be[i]      = view_be[i] | st_be;
        view_spec[i].rd = view_spec[i].rd | st_spec_rd;
        view_spec[i].wr = view_spec[i].wr | st_spec_wr;
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (st_be[b]) view_data[i][b*8 +: 8] = st_data[b*8 +: 8];
        end
      end
    end
  end

  // One entry per line, so at most one drain_hit bit is set
  always_comb begin
    sel_data = '0;
    sel_be   = '0;
    sel_spec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (drain_hit[i]) begin
        sel_data = sel_data | view_data[i];
        sel_be   = sel_be | view_be[i];
        sel_spec = sel_spec | view_spec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (drain_hit[i])     valid_q[i] <= 1'b0;
        else if (alloc_en[i]) valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc_en[i]) tag_q[i] <= st_line;
      if (wr_en[i]) begin
        data_q[i] <= view_data[i];
        be_q[i]   <= view_be[i];
        spec_q[i] <= view_spec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drain_valid <= 1'b0;
    else     drain_valid <= |drain_hit;
  end

  always_ff @(posedge clk) begin
    if (|drain_hit) begin
      drain_line    <= grant_line;
      drain_data    <= sel_data;
      drain_be      <= sel_be;
      drain_spec_rd <= sel_spec.rd;
      drain_spec_wr <= sel_spec.wr;
    end
  end
endmodule

// File: rtl/csb_checker.sv
`timescale 1ns/1ps
module csb_checker #(
  parameter int LINE_BYTES = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  st_valid,
  input logic                  st_l1_hit,
  input logic                  st_stall,
  input logic                  grant_valid,
  input logic                  drain_valid,
  input logic [LINE_BYTES-1:0] drain_be,
  input logic                  sb_empty,
  input logic                  sb_full
);
  // R5
  stall_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    st_stall |-> sb_full);

  // R5
  refused_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    (sb_full && st_stall && !grant_valid) |=> sb_full);

  // R2
  bypass_keeps_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_l1_hit && sb_empty) |=> sb_empty);

  // R6
  drain_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    drain_valid |-> $past(grant_valid));

  // R6
  drain_mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    drain_valid |-> (drain_be != '0));

  // R8
  empty_rise_drain_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sb_empty) |-> drain_valid);

  // R7
  idle_grant_no_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && sb_empty) |=> !drain_valid);
endmodule

bind coal_store_buf csb_checker #(.LINE_BYTES(LINE_BYTES)) u_csb_chk (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_l1_hit(st_l1_hit),
  .st_stall(st_stall), .grant_valid(grant_valid), .drain_valid(drain_valid),
  .drain_be(drain_be), .sb_empty(sb_empty), .sb_full(sb_full)
);

// File: tb/coal_store_buf_test.sv
`timescale 1ns/1ps
module coal_store_buf_test;
  localparam int N  = 8;
  localparam int LW = 26;
  localparam int LB = 8;
  localparam int DW = LB * 8;

  logic clk = 1'b0, rst = 1'b1;
  logic st_valid = 0, st_l1_hit = 0, st_spec_rd = 0, st_spec_wr = 0, grant_valid = 0;
  logic [LW-1:0] st_line = '0, grant_line = '0;
  logic [DW-1:0] st_data = '0;
  logic [LB-1:0] st_be = '0;
  logic st_stall, drain_valid, drain_spec_rd, drain_spec_wr, sb_empty, sb_full;
  logic [LW-1:0] drain_line;
  logic [DW-1:0] drain_data;
  logic [LB-1:0] drain_be;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of slots
  bit            m_v    [N];
  logic [LW-1:0] m_line [N];
  logic [DW-1:0] m_data [N];
  logic [LB-1:0] m_be   [N];
  bit            m_rd   [N];
  bit            m_wr   [N];

  always #10 clk = ~clk;

  coal_store_buf #(.ENTRIES(N), .LINE_W(LW), .LINE_BYTES(LB)) uut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_l1_hit(st_l1_hit),
    .st_line(st_line), .st_data(st_data), .st_be(st_be),
    .st_spec_rd(st_spec_rd), .st_spec_wr(st_spec_wr), .st_stall(st_stall),
    .grant_valid(grant_valid), .grant_line(grant_line),
    .drain_valid(drain_valid), .drain_line(drain_line), .drain_data(drain_data),
    .drain_be(drain_be), .drain_spec_rd(drain_spec_rd), .drain_spec_wr(drain_spec_wr),
    .sb_empty(sb_empty), .sb_full(sb_full)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int find_line(logic [LW-1:0] ln);
    for (int i = 0; i < N; i++) if (m_v[i] && m_line[i] == ln) return i;
    return -1;
  endfunction

  function automatic int occupancy();
    int c = 0;
    for (int i = 0; i < N; i++) if (m_v[i]) c++;
    return c;
  endfunction

  function automatic logic [DW-1:0] merge_bytes(logic [DW-1:0] old, logic [DW-1:0] nw,
                                                logic [LB-1:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < LB; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // One cycle: drive after negedge, check combinational/state, then drain next negedge
  task automatic step(bit sv, bit hit, logic [LW-1:0] ln, logic [DW-1:0] d,
                      logic [LB-1:0] be, bit rd, bit wr, bit gv,
                      logic [LW-1:0] gl, string req);
    int mi, gi, occ;
    bit take, exp_stall, exp_dv;
    logic [LW-1:0] e_line; logic [DW-1:0] e_data; logic [LB-1:0] e_be; bit e_rd, e_wr;
    st_valid = sv; st_l1_hit = hit; st_line = ln; st_data = d; st_be = be;
    st_spec_rd = rd; st_spec_wr = wr; grant_valid = gv; grant_line = gl;
    #1;
    occ  = occupancy();
    mi   = find_line(ln);
    take = sv && !hit;
    exp_stall = take && (mi < 0) && (occ == N);
    chk("R5 stall", st_stall, exp_stall);
    chk("R5 full", sb_full, occ == N);
    chk("R8 empty", sb_empty, occ == 0);
    gi = gv ? find_line(gl) : -1;
    if (take) begin
      if (mi >= 0) begin
        m_data[mi] = merge_bytes(m_data[mi], d, be);
        m_be[mi] |= be; m_rd[mi] |= rd; m_wr[mi] |= wr;
      end else if (occ < N) begin
        for (int i = 0; i < N; i++) if (!m_v[i]) begin
          m_v[i] = 1; m_line[i] = ln; m_data[i] = merge_bytes('0, d, be);
          m_be[i] = be; m_rd[i] = rd; m_wr[i] = wr;
          break;
        end
      end
    end
    exp_dv = (gi >= 0);
    if (exp_dv) begin
      e_line = m_line[gi]; e_data = m_data[gi]; e_be = m_be[gi];
      e_rd = m_rd[gi]; e_wr = m_wr[gi]; m_v[gi] = 0;
    end
    @(posedge clk); @(negedge clk);
    chk({req, " drain_valid"}, drain_valid, exp_dv);
    if (exp_dv) begin
      chk({req, " line"}, drain_line, e_line);
      chk({req, " data"}, drain_data, e_data);
      chk({req, " mask"}, drain_be, e_be);
      chk({req, " rd"}, drain_spec_rd, e_rd);
      chk({req, " wr"}, drain_spec_wr, e_wr);
    end
  endtask

  task automatic idle(); step(0, 0, '0, '0, '0, 0, 0, 0, '0, "R6"); endtask

  localparam logic [LW-1:0] BASE = 26'h0100;

  initial begin
    int s;
    s = $urandom(32'd4242);
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 empty", sb_empty, 1); chk("R1 full", sb_full, 0); chk("R1 drain", drain_valid, 0);

    // R3 allocation, unwritten bytes zero, then R6 drain
    step(1, 0, BASE, 64'h1122334455667788, 8'h0F, 0, 1, 0, '0, "R3");
    idle();
    step(0, 0, '0, '0, '0, 0, 0, 1, BASE, "R3");

    // R4 overlapping merge, newer bytes win, flags OR
    step(1, 0, BASE+1, 64'hAAAAAAAAAAAAAAAA, 8'h3C, 1, 0, 0, '0, "R4");
    step(1, 0, BASE+1, 64'h5555555555555555, 8'h0F, 0, 1, 0, '0, "R4");
    step(0, 0, '0, '0, '0, 0, 0, 1, BASE+1, "R4");

    // R2 bypass: L1 hit store not held, grant yields nothing
    step(1, 1, BASE+2, 64'hDEAD, 8'h03, 1, 1, 0, '0, "R2");
    step(0, 0, '0, '0, '0, 0, 0, 1, BASE+2, "R2");

    // R5 fill all slots, refuse a new line, accept a merge while full
    for (int i = 0; i < N; i++)
      step(1, 0, BASE+16+i, {8{8'(i+1)}}, 8'h01 << i, 0, 0, 0, '0, "R5");
    step(1, 0, BASE+40, 64'hFF, 8'hFF, 0, 0, 0, '0, "R5");
    step(1, 0, BASE+18, 64'hBEEF0000, 8'hF0, 1, 0, 0, '0, "R5");
    // R7 absent-line grant ignored while entries held
    step(0, 0, '0, '0, '0, 0, 0, 1, BASE+40, "R7");
    // R6 release out of order; R8 empty with last drain
    for (int i = N-1; i >= 0; i--)
      step(0, 0, '0, '0, '0, 0, 0, 1, BASE+16+((i*3)%N), "R6");

    // R9 store and grant on the same held line in one cycle
    step(1, 0, BASE+5, 64'h0000000000C0FFEE, 8'h07, 0, 0, 0, '0, "R9");
    step(1, 0, BASE+5, 64'h7700000000000000, 8'hC0, 1, 1, 1, BASE+5, "R9");

    // random mix over a small pool of lines
    for (int k = 0; k < 3000; k++) begin
      logic [LB-1:0] be;
      be = 8'($urandom);
      if (be == 0) be = 8'h01;
      step(($urandom % 10) < 6, ($urandom % 10) < 2, BASE + LW'($urandom % 12),
           {$urandom, $urandom}, be, ($urandom % 4) == 0, ($urandom % 3) == 0,
           ($urandom % 4) == 0, BASE + LW'($urandom % 12), "R6 R4");
    end
    for (int j = 0; j < 12; j++) step(0, 0, '0, '0, '0, 0, 0, 1, BASE + LW'(j), "R8");
    chk("R8 final empty", sb_empty, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule